// File: doc/BRIEF.md
# Maskable Latched Interrupt Controller

This block gathers up to 32 interrupt lines next to a processor core and turns them into a single request. Each line has a pending latch. A line that is set to level mode sets its latch on every cycle it is high. A line that is set to edge mode sets its latch only on a rising transition. Once set, a latch stays set until software acknowledges it. A separately written enable register selects which pending lines may raise the request. The request is also gated by the core's own interrupt-enable bit.

Software reaches the block through one register port. The port selects either the enable register or the pending register, and the selected register can be written and read back. A write to the pending register only acknowledges bits. A parameter chooses which data value clears a bit: a 1 or a 0. Because a high level line sets its latch again during an acknowledge, software can acknowledge every line the same way without knowing its trigger type. Along with the request, the block gives the index of the lowest-numbered enabled pending line. This matches the order in which service software scans the pending register.

Top module: `pic_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the enable register and the pending register read 0, `irq_req` is 0 and `irq_id` is 0.
- R2: A write with `reg_sel`=0 loads `reg_wdata` into the enable register at the next clock edge. While `reg_sel`=0, `reg_rdata` returns the enable register.
- R3: For a line whose bit in `EDGE_SRC` is 0 (level mode), a high input sets its pending bit at the next edge. The bit stays set after the input falls.
- R4: For a line whose bit in `EDGE_SRC` is 1 (edge mode), the pending bit is set only when the input is high and was low in the previous cycle. A line held high does not set the bit again after an acknowledge.
- R5: A write with `reg_sel`=1 clears every pending bit whose data bit equals `ACK_ON_ONE` (1 clears when `ACK_ON_ONE`=1, 0 clears when `ACK_ON_ONE`=0). Every other pending bit is kept.
- R6: If a line requests a set in the same cycle that its bit is acknowledged, the set wins and the bit reads 1 afterwards.
- R7: `irq_req` is a register. It is loaded with `core_ie` AND the OR of (pending AND enable), so it follows a change one cycle later. It is 0 whenever `core_ie` was 0 in the previous cycle.
- R8: `irq_id` is registered together with `irq_req`. It holds the lowest index of an enabled pending line, and it is 0 when no enabled line is pending.
- R9: A write to the pending register never sets a bit.
- R10: The enable register does not affect latching: a line that is not enabled still sets its pending bit, but it raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_SRC | Interrupt lines |
| core_ie | input | 1 | Interrupt-enable bit from the core |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 enable register, 1 pending register |
| reg_wdata | input | NUM_SRC | Write data |
| reg_rdata | output | NUM_SRC | Read data of the selected register |
| irq_req | output | 1 | Registered interrupt request to the core |
| irq_id | output | $clog2(NUM_SRC) | Lowest enabled pending line index |

## Verification
The assertions check four properties on every cycle. A requested set always lands in the pending register, even during an acknowledge. An acknowledge clears exactly the bits that its polarity selects. No pending bit appears without a set. And the request, the reported index and the enable register track their sources with one cycle of delay. Other behaviour shows only in bench scenarios. These scenarios cover how each line reacts according to its trigger type, in particular whether a held-high line returns after an acknowledge, and the lowest-index choice under a range of enable patterns. They also compare two builds, one with each acknowledge polarity, on identical traffic.

// File: rtl/pic_pkg.sv
// Package: shared definitions for the interrupt controller.
// Assumes the register port selects between exactly two registers.
package pic_pkg;

    // Register select encoding of the software port.
    typedef enum logic {
        PIC_SEL_ENABLE  = 1'b0,
        PIC_SEL_PENDING = 1'b1
    } pic_sel_e;

endpackage

// File: rtl/pic_trig.sv
// Module: pic_trig
// Turns each raw interrupt line into a one-cycle set request.
// Level lines request a set while they are high. Edge lines request a set on
// a rising transition, found by comparing the line with a one-cycle-delayed
// copy. Assumes the inputs are already synchronous to clk.
module pic_trig #(
    parameter int               NUM_SRC  = 32,
    parameter logic [NUM_SRC-1:0] EDGE_SRC = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    output logic [NUM_SRC-1:0] set_vec
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (EDGE_SRC[g]) begin : g_edge
            logic prev_q;

            // Keeps the previous cycle's level for rising-edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= irq_in[g];
            end

            // A set is requested only on a low-to-high transition.
            always_comb set_vec[g] = irq_in[g] & ~prev_q;

            AST_EDGE_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
                set_vec[g] |=> !set_vec[g]);   // R4
        end else begin : g_level
            // A set is requested on every cycle the line is high.
            always_comb set_vec[g] = irq_in[g];
        end
    end

endmodule

// File: rtl/pic_status.sv
// Module: pic_status
// Pending register. Set requests OR into the latches, and acknowledge writes
// clear the bits whose data bit equals ACK_ON_ONE. A set and a clear of the
// same bit in one cycle leave the bit set.
// Assumes wr_pend is a single-cycle strobe qualified by the register select.
module pic_status #(
    parameter int NUM_SRC    = 32,
    parameter bit ACK_ON_ONE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic               wr_pend,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] pend_q
);

    logic [NUM_SRC-1:0] clr_vec;

    // Decodes the acknowledge polarity into a clear vector.
    always_comb begin
        if (!wr_pend)        clr_vec = '0;
        else if (ACK_ON_ONE) clr_vec = wdata;
        else                 clr_vec = ~wdata;
    end

    // Updates the latches, with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_vec) | set_vec;
    end

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(set_vec)) == $past(set_vec)));   // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |=> ((pend_q & (ACK_ON_ONE ? $past(wdata) : ~$past(wdata))
                     & ~$past(set_vec)) == '0));                       // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~($past(pend_q) | $past(set_vec))) == '0)); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pend |=> ((pend_q & $past(pend_q)) == $past(pend_q)));    // R3

endmodule

// File: rtl/pic_lowest.sv
// Module: pic_lowest
// Finds the lowest set bit of a vector, which is the service order software
// uses. Purely combinational. The index is 0 when no bit is set.
module pic_lowest #(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0]         vec,
    output logic                       found,
    output logic [$clog2(NUM_SRC)-1:0] idx
);

    localparam int IDX_W = $clog2(NUM_SRC);

    // Scans from the top down so that the lowest set bit is assigned last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pic_ctrl.sv
// Module: pic_ctrl
// Top of the interrupt controller: trigger detection, pending latches, the
// enable register, lowest-index selection and the registered request to the
// core. Assumes one software port access per cycle, synchronous to clk.
module pic_ctrl #(
    parameter int                 NUM_SRC    = 32,
    parameter logic [NUM_SRC-1:0] EDGE_SRC   = 32'h0000_FF00,
    parameter bit                 ACK_ON_ONE = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         irq_in,
    input  logic                       core_ie,
    input  logic                       reg_wr,
    input  logic                       reg_sel,
    input  logic [NUM_SRC-1:0]         reg_wdata,
    output logic [NUM_SRC-1:0]         reg_rdata,
    output logic                       irq_req,
    output logic [$clog2(NUM_SRC)-1:0] irq_id
);

    import pic_pkg::*;

    localparam int                 IDX_W = $clog2(NUM_SRC);
    localparam logic [NUM_SRC-1:0] ONE   = NUM_SRC'(1);

    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] active_vec;
    logic               low_found;
    logic [IDX_W-1:0]   low_idx;
    logic               wr_enable;
    logic               wr_pend;
    logic [NUM_SRC-1:0] below_low;

    // Decodes the write strobe to the two registers.
    always_comb begin
        wr_enable = reg_wr && (pic_sel_e'(reg_sel) == PIC_SEL_ENABLE);
        wr_pend   = reg_wr && (pic_sel_e'(reg_sel) == PIC_SEL_PENDING);
    end

    pic_trig #(.NUM_SRC(NUM_SRC), .EDGE_SRC(EDGE_SRC)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .set_vec (set_vec)
    );

    pic_status #(.NUM_SRC(NUM_SRC), .ACK_ON_ONE(ACK_ON_ONE)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .wr_pend (wr_pend),
        .wdata   (reg_wdata),
        .pend_q  (pend_q)
    );

    // Holds the per-line enable bits written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)         enable_q <= '0;
        else if (wr_enable) enable_q <= reg_wdata;
    end

    // Forms the enabled pending set.
    always_comb active_vec = pend_q & enable_q;

    pic_lowest #(.NUM_SRC(NUM_SRC)) u_lowest (
        .vec   (active_vec),
        .found (low_found),
        .idx   (low_idx)
    );

    // Registers the gated request and its index for the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_id  <= '0;
        end else begin
            irq_req <= core_ie && low_found;
            irq_id  <= low_found ? low_idx : '0;
        end
    end

    // Returns the register chosen by the select.
    always_comb begin
        if (pic_sel_e'(reg_sel) == PIC_SEL_ENABLE) reg_rdata = enable_q;
        else                                       reg_rdata = pend_q;
    end

    // Mask of the bits below the chosen index, used only by the check below.
    always_comb below_low = (ONE << low_idx) - ONE;

    AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enable |=> (enable_q == $past(reg_wdata)));                  // R2
    AST_REQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(core_ie));                                     // R7
    AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ie && (active_vec != '0)) |=> irq_req);                    // R7
    AST_ID_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        low_found |-> (active_vec[low_idx] && ((active_vec & below_low) == '0))); // R8
    AST_ID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (active_vec == '0) |=> (irq_id == '0));                          // R8

endmodule

// File: tb/test_pic_ctrl.sv
// Bench: sweeps every line of two builds that differ only in acknowledge
// polarity, and computes expected values arithmetically.
module test_pic_ctrl;

    localparam int          N    = 32;
    localparam logic [31:0] EDGE = 32'h0000_FF00;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          core_ie = 1'b1;
    logic          reg_wr = 1'b0;
    logic          reg_sel = 1'b0;
    logic [N-1:0]  wdata_a = '0;
    logic [N-1:0]  wdata_b = '0;
    logic [N-1:0]  rdata_a, rdata_b;
    logic          req_a, req_b;
    logic [4:0]    id_a, id_b;
    int            total = 0;
    int            bad = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    pic_ctrl #(.NUM_SRC(N), .EDGE_SRC(EDGE), .ACK_ON_ONE(1'b1)) i_pic_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .core_ie(core_ie),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(wdata_a),
        .reg_rdata(rdata_a), .irq_req(req_a), .irq_id(id_a));

    pic_ctrl #(.NUM_SRC(N), .EDGE_SRC(EDGE), .ACK_ON_ONE(1'b0)) i_pic_ctrl_inv (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .core_ie(core_ie),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(wdata_b),
        .reg_rdata(rdata_b), .irq_req(req_b), .irq_id(id_b));

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // The inverted-polarity build receives inverted data on pending writes.
    task automatic wr_reg(input logic sel, input logic [31:0] v);
        reg_wr  = 1'b1;
        reg_sel = sel;
        wdata_a = v;
        wdata_b = sel ? ~v : v;
        step();
        reg_wr  = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [31:0] exp, input string tag);
        reg_sel = sel;
        #1;
        chk(rdata_a, exp, tag);
        chk(rdata_b, exp, {tag, " inv"});
    endtask

    task automatic chk_irq(input logic r, input logic [4:0] id, input string tag);
        chk({31'b0, req_a}, {31'b0, r}, tag);
        chk({31'b0, req_b}, {31'b0, r}, {tag, " inv"});
        chk({27'b0, id_a}, {27'b0, id}, tag);
        chk({27'b0, id_b}, {27'b0, id}, {tag, " inv"});
    endtask

    function automatic int lowest(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return -1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        rd(1'b0, 32'h0, "R1 enable reset");
        rd(1'b1, 32'h0, "R1 pending reset");
        chk_irq(1'b0, 5'd0, "R1 request reset");

        // R10 disabled line still latches but raises no request
        irq_in = 32'h8; step(); irq_in = '0; step();
        rd(1'b1, 32'h8, "R10 latch while disabled");
        chk_irq(1'b0, 5'd0, "R10 no request");
        wr_reg(1'b1, 32'h8);
        rd(1'b1, 32'h0, "R5 clear after R10");

        // R2 enable register load and readback
        wr_reg(1'b0, 32'hDEAD_BEEF);
        rd(1'b0, 32'hDEAD_BEEF, "R2 enable readback");
        wr_reg(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, 32'hFFFF_FFFF, "R2 enable all");

        // Per-line sweep of latch, latency, acknowledge and trigger type.
        for (int i = 0; i < N; i++) begin
            logic [31:0] v;
            bit          e;
            v = 32'h1 << i;
            e = EDGE[i];
            irq_in = v; step();
            rd(1'b1, v, e ? "R4 edge latch" : "R3 level latch");
            chk_irq(1'b0, 5'd0, "R7 one-cycle latency");
            step();
            chk_irq(1'b1, 5'(i), "R8 single line index");
            wr_reg(1'b1, v);
            rd(1'b1, e ? 32'h0 : v, e ? "R4 held edge not re-set" : "R6 set beats ack");
            irq_in = '0; step();
            rd(1'b1, e ? 32'h0 : v, "R3 hold after input falls");
            wr_reg(1'b1, v);
            rd(1'b1, 32'h0, "R5 ack clears");
        end

        // R9 a pending write cannot set bits
        wr_reg(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, 32'h0, "R9 write sets nothing");
        wr_reg(1'b1, 32'h0);
        rd(1'b1, 32'h0, "R9 write sets nothing opposite data");

        // R5 polarity: the non-clearing data value keeps every bit
        irq_in = 32'h8001_0F0F; step(); irq_in = '0; step();
        rd(1'b1, 32'h8001_0F0F, "R5 pattern latched");
        wr_reg(1'b1, 32'h0);
        rd(1'b1, 32'h8001_0F0F, "R5 keeping value keeps");
        wr_reg(1'b1, 32'h0000_0F00);
        rd(1'b1, 32'h8001_000F, "R5 partial ack");
        wr_reg(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, 32'h0, "R5 full ack");

        // R8/R7 lowest-index sweep under varied enable patterns.
        for (int k = 0; k < N; k++) begin
            logic [31:0] p, m, a;
            int          lo;
            p = (32'hA5A5_5A5A | (32'h1 << k)) & ~((32'h1 << k) - 32'h1);
            irq_in = p; step(); irq_in = '0; step();
            chk_irq(1'b1, 5'(k), "R8 lowest pending");
            m = ~(32'h1 << k);
            wr_reg(1'b0, m);
            step();
            a  = p & m;
            lo = lowest(a);
            chk_irq(lo >= 0, lo >= 0 ? 5'(lo) : 5'd0, "R8 lowest under enable");
            core_ie = 1'b0; step();
            chk_irq(1'b0, lo >= 0 ? 5'(lo) : 5'd0, "R7 gated by core enable");
            core_ie = 1'b1;
            wr_reg(1'b1, 32'hFFFF_FFFF);
            step();
            chk_irq(1'b0, 5'd0, "R7 drops after ack");
            wr_reg(1'b0, 32'hFFFF_FFFF);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule